// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the opening Start condition for an I2C bus master driving an open-drain SDA/SCL pair. Software raises a one-cycle start request. The block first confirms that both lines read high. It then waits one baud period with both lines released. Next it pulls SDA low while SCL stays high, and it waits a second baud period with SDA held. At that point the request is complete and a completion flag is raised. A reloadable down counter times both waits. The reload value is taken from an 8-bit input each time the counter is loaded.

The sampled line levels are checked before the SDA fall. Another driver holding either line low is treated as a bus collision. On a collision the block raises a sticky collision flag, drops the request and returns to idle with both lines released. The completion and collision flags remain set until a write-one-to-clear strobe clears them. After a successful Start, SDA stays pulled low until the downstream transfer logic pulses a release strobe.

The sequencer has three states: `ST_IDLE`, `ST_SETUP` (first baud period, lines released) and `ST_HOLD` (second baud period, SDA pulled). It has five transitions:
- BEGIN: `ST_IDLE`→`ST_SETUP`, on a request with both lines high.
- REFUSE: `ST_IDLE`→`ST_IDLE`, on a request with a line low. This flags a collision.
- FALL: `ST_SETUP`→`ST_HOLD`, when the first period expires with both lines high.
- ABORT: `ST_SETUP`→`ST_IDLE`, when either line is sampled low.
- FINISH: `ST_HOLD`→`ST_IDLE`, when the second period expires.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, every output is 0.
- R2: A start request accepted with both lines high sets `start_en_o` on the next clock edge. SDA then stays released for (reload+1) cycles.
- R3: SDA is pulled and `start_seen_o` set exactly reload+1 clock cycles after `start_en_o` rises. `scl_pull_o` stays 0 throughout.
- R4: Exactly reload+1 cycles after SDA is pulled, `start_en_o` clears and `done_flag_o` sets, while SDA remains pulled.
- R5: A reload value of 0 gives baud periods of one clock each. The whole Start then takes 2 cycles from `start_en_o` rising to completion.
- R6: A start request seen while SDA or SCL reads low sets `bcol_flag_o` on the next edge. `start_en_o` stays 0 and SDA is not pulled.
- R7: If SCL or SDA reads low during the first period, the next edge sets `bcol_flag_o`, clears `start_en_o` and leaves SDA released with `start_seen_o` at 0.
- R8: `done_flag_o` and `bcol_flag_o` hold their value until their clear strobe (`clr_done_i`, `clr_bcol_i`, active 1) is sampled. The flag then reads 0 on the next edge.
- R9: Start requests are ignored while `bcol_flag_o` is set, and also while a Start is in progress. An ignored request leaves the outputs and the completion timing unchanged.
- R10: A `bus_release_i` pulse in idle releases SDA and clears `start_seen_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_req_i | input | 1 | One-cycle start request |
| reload_i | input | 8 | Baud counter reload value; period = reload+1 clocks |
| sda_i | input | 1 | Sampled SDA line level |
| scl_i | input | 1 | Sampled SCL line level |
| clr_done_i | input | 1 | Write-one-to-clear strobe for the completion flag |
| clr_bcol_i | input | 1 | Write-one-to-clear strobe for the collision flag |
| bus_release_i | input | 1 | Releases the held SDA after a completed Start |
| sda_pull_o | output | 1 | Open-drain pull-low enable for SDA |
| scl_pull_o | output | 1 | Open-drain pull-low enable for SCL (never asserted by this block) |
| start_en_o | output | 1 | Start in progress; cleared by hardware on completion or abort |
| start_seen_o | output | 1 | Start condition driven on the bus |
| done_flag_o | output | 1 | Sticky completion interrupt flag |
| bcol_flag_o | output | 1 | Sticky bus-collision interrupt flag |

## Verification
Every output is registered. A request or strobe sampled at edge k therefore shows at edge k itself. The SDA fall follows reload+1 edges after that, and completion follows another reload+1 edges. A line forced low shows as a collision on the very next edge. The bench changes its inputs on falling edges and waits the counted number of falling edges before it reads the outputs. Each check therefore lands in the single cycle the requirement names. It also reads the cycle before each SDA fall and completion, to confirm that neither event happens one cycle early.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_e;

    localparam int unsigned BAUD_W = 8;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int unsigned STAGES = 0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sda_i,
    input  logic scl_i,
    output logic both_hi_o
);

    logic sda_s;
    logic scl_s;

    generate
        if (STAGES == 0) begin : g_direct
            assign sda_s = sda_i;
            assign scl_s = scl_i;
        end else begin : g_sync
            logic [STAGES-1:0] sda_q;
            logic [STAGES-1:0] scl_q;
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) begin
                        sda_q[i] <= 1'b1;
                        scl_q[i] <= 1'b1;
                    end else begin
                        sda_q[i] <= (i == 0) ? sda_i : sda_q[(i == 0) ? 0 : i-1];
                        scl_q[i] <= (i == 0) ? scl_i : scl_q[(i == 0) ? 0 : i-1];
                    end
                end
            end
            assign sda_s = sda_q[STAGES-1];
            assign scl_s = scl_q[STAGES-1];
        end
    endgenerate

    assign both_hi_o = sda_s & scl_s;

endmodule

// File: rtl/i2c_baud_counter.sv
module i2c_baud_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         run_i,
    input  logic [W-1:0] reload_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    p_load_takes_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == $past(reload_i)));

    p_run_steps_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_idle_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    p_clear_takes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> !flag_o);

    p_holds_without_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
    import i2c_start_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_req_i,
    input  logic both_hi_i,
    input  logic release_i,
    input  logic bcol_flag_i,
    input  logic cnt_expired_i,
    output logic cnt_load_o,
    output logic cnt_run_o,
    output logic done_set_o,
    output logic bcol_set_o,
    output logic start_en_o,
    output logic start_seen_o,
    output logic sda_pull_o
);

    seq_state_e state_q, state_d;
    logic       en_q, en_d;
    logic       seen_q, seen_d;
    logic       pull_q, pull_d;

    always_comb begin
        state_d    = state_q;
        en_d       = en_q;
        seen_d     = seen_q;
        pull_d     = pull_q;
        cnt_load_o = 1'b0;
        cnt_run_o  = 1'b0;
        done_set_o = 1'b0;
        bcol_set_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req_i && !bcol_flag_i) begin
                    if (both_hi_i) begin
                        // BEGIN
                        state_d    = ST_SETUP;
                        cnt_load_o = 1'b1;
                        en_d       = 1'b1;
                        seen_d     = 1'b0;
                    end else begin
                        // REFUSE
                        bcol_set_o = 1'b1;
                        en_d       = 1'b0;
                        seen_d     = 1'b0;
                        pull_d     = 1'b0;
                    end
                end else if (release_i) begin
                    pull_d = 1'b0;
                    seen_d = 1'b0;
                end
            end
            ST_SETUP: begin
                if (!both_hi_i) begin
                    // ABORT
                    state_d    = ST_IDLE;
                    bcol_set_o = 1'b1;
                    en_d       = 1'b0;
                    seen_d     = 1'b0;
                    pull_d     = 1'b0;
                end else if (cnt_expired_i) begin
                    // FALL
                    state_d    = ST_HOLD;
                    cnt_load_o = 1'b1;
                    pull_d     = 1'b1;
                    seen_d     = 1'b1;
                end else begin
                    cnt_run_o = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_expired_i) begin
                    // FINISH
                    state_d    = ST_IDLE;
                    en_d       = 1'b0;
                    done_set_o = 1'b1;
                end else begin
                    cnt_run_o = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                en_d    = 1'b0;
                pull_d  = 1'b0;
                seen_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q   <= 1'b0;
            seen_q <= 1'b0;
            pull_q <= 1'b0;
        end else begin
            en_q   <= en_d;
            seen_q <= seen_d;
            pull_q <= pull_d;
        end
    end

    assign start_en_o   = en_q;
    assign start_seen_o = seen_q;
    assign sda_pull_o   = pull_q;

    p_fall_from_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_pull_o) |-> ($past(state_q) == ST_SETUP) && start_en_o);

    p_finish_keeps_sda_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_set_o |=> (sda_pull_o && !start_en_o && state_q == ST_IDLE));

    p_abort_releases_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bcol_set_o |=> (!start_en_o && !sda_pull_o && !start_seen_o));

    p_flagged_stays_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && bcol_flag_i) |=> (state_q == ST_IDLE));

    p_busy_matches_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |-> start_en_o);

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2c_start_pkg::*;
#(
    parameter int unsigned RELOAD_W    = BAUD_W,
    parameter int unsigned SYNC_STAGES = 0
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_req_i,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic                sda_i,
    input  logic                scl_i,
    input  logic                clr_done_i,
    input  logic                clr_bcol_i,
    input  logic                bus_release_i,
    output logic                sda_pull_o,
    output logic                scl_pull_o,
    output logic                start_en_o,
    output logic                start_seen_o,
    output logic                done_flag_o,
    output logic                bcol_flag_o
);

    logic both_hi;
    logic cnt_load;
    logic cnt_run;
    logic cnt_expired;
    logic done_set;
    logic bcol_set;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sda_i     (sda_i),
        .scl_i     (scl_i),
        .both_hi_o (both_hi)
    );

    i2c_baud_counter #(.W(RELOAD_W)) u_baud (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (cnt_load),
        .run_i     (cnt_run),
        .reload_i  (reload_i),
        .expired_o (cnt_expired)
    );

    i2c_start_seq u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_req_i   (start_req_i),
        .both_hi_i     (both_hi),
        .release_i     (bus_release_i),
        .bcol_flag_i   (bcol_flag_o),
        .cnt_expired_i (cnt_expired),
        .cnt_load_o    (cnt_load),
        .cnt_run_o     (cnt_run),
        .done_set_o    (done_set),
        .bcol_set_o    (bcol_set),
        .start_en_o    (start_en_o),
        .start_seen_o  (start_seen_o),
        .sda_pull_o    (sda_pull_o)
    );

    i2c_sticky_flag u_done_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (done_set),
        .clr_i  (clr_done_i),
        .flag_o (done_flag_o)
    );

    i2c_sticky_flag u_bcol_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (bcol_set),
        .clr_i  (clr_bcol_i),
        .flag_o (bcol_flag_o)
    );

    // SCL is left to the pull-up for the whole Start sequence.
    assign scl_pull_o = 1'b0;

    p_seen_with_pull_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_pull_o |-> start_seen_o);

    p_done_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_flag_o) |-> (sda_pull_o && !start_en_o));

    p_bcol_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bcol_flag_o) |-> (!start_en_o && !sda_pull_o));

endmodule

// File: tb/i2c_start_gen_tb_top.sv
module i2c_start_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic [7:0] reload = 8'd0;
    logic       ext_sda_low = 1'b0;
    logic       ext_scl_low = 1'b0;
    logic       clr_done = 1'b0;
    logic       clr_bcol = 1'b0;
    logic       bus_release = 1'b0;
    logic       sda_pull, scl_pull, start_en, start_seen, done_flag, bcol_flag;
    logic       sda_line, scl_line;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign sda_line = !sda_pull && !ext_sda_low;
    assign scl_line = !scl_pull && !ext_scl_low;

    i2c_start_gen dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_req_i   (start_req),
        .reload_i      (reload),
        .sda_i         (sda_line),
        .scl_i         (scl_line),
        .clr_done_i    (clr_done),
        .clr_bcol_i    (clr_bcol),
        .bus_release_i (bus_release),
        .sda_pull_o    (sda_pull),
        .scl_pull_o    (scl_pull),
        .start_en_o    (start_en),
        .start_seen_o  (start_seen),
        .done_flag_o   (done_flag),
        .bcol_flag_o   (bcol_flag)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_req();
        start_req = 1'b1; tick(); start_req = 1'b0;
    endtask

    task automatic pulse_clr_done();
        clr_done = 1'b1; tick(); clr_done = 1'b0;
    endtask

    task automatic pulse_clr_bcol();
        clr_bcol = 1'b1; tick(); clr_bcol = 1'b0;
    endtask

    task automatic pulse_release();
        bus_release = 1'b1; tick(); bus_release = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 start_en", start_en, 0);
        chk("R1 start_seen", start_seen, 0);
        chk("R1 done_flag", done_flag, 0);
        chk("R1 bcol_flag", bcol_flag, 0);
    endtask

    // Full Start with reload r; optionally inject a request during the hold phase.
    task automatic t_start(int r, bit poke_busy, string tag);
        reload = 8'(r);
        pulse_req();
        chk({tag, " R2 start_en rises"}, start_en, 1);
        chk({tag, " R2 sda released"}, sda_pull, 0);
        repeat (r) tick();
        chk({tag, " R3 sda not early"}, sda_pull, 0);
        tick();
        chk({tag, " R3 sda pulled"}, sda_pull, 1);
        chk({tag, " R3 start_seen"}, start_seen, 1);
        chk({tag, " R3 scl untouched"}, scl_pull, 0);
        if (poke_busy && r > 0) begin
            pulse_req();              // R9: ignored while busy
            repeat (r - 1) tick();
        end else begin
            repeat (r) tick();
        end
        chk({tag, " R4 not early done"}, done_flag, 0);
        chk({tag, " R4 not early en"}, start_en, 1);
        tick();
        chk({tag, " R4 done set"}, done_flag, 1);
        chk({tag, " R4 en cleared"}, start_en, 0);
        chk({tag, " R4 sda held"}, sda_pull, 1);
        chk({tag, " R9 no collision"}, bcol_flag, 0);
        tick(); tick();
        chk({tag, " R8 done sticky"}, done_flag, 1);
        pulse_clr_done();
        chk({tag, " R8 done cleared"}, done_flag, 0);
        pulse_release();
        chk({tag, " R10 sda released"}, sda_pull, 0);
        chk({tag, " R10 seen cleared"}, start_seen, 0);
    endtask

    task automatic t_refuse(bit sda_side);
        reload = 8'd4;
        if (sda_side) ext_sda_low = 1'b1; else ext_scl_low = 1'b1;
        pulse_req();
        chk("R6 bcol set", bcol_flag, 1);
        chk("R6 no start_en", start_en, 0);
        chk("R6 sda free", sda_pull, 0);
        ext_sda_low = 1'b0; ext_scl_low = 1'b0;
        tick();
        pulse_req();              // R9: flagged, ignored
        chk("R9 ignored start_en", start_en, 0);
        repeat (7) tick();
        chk("R9 ignored sda", sda_pull, 0);
        chk("R8 bcol sticky", bcol_flag, 1);
        pulse_clr_bcol();
        chk("R8 bcol cleared", bcol_flag, 0);
    endtask

    task automatic t_abort(bit sda_side);
        reload = 8'd5;
        pulse_req();
        tick();
        if (sda_side) ext_sda_low = 1'b1; else ext_scl_low = 1'b1;
        tick();
        chk("R7 bcol set", bcol_flag, 1);
        chk("R7 en cleared", start_en, 0);
        chk("R7 sda free", sda_pull, 0);
        chk("R7 seen clear", start_seen, 0);
        ext_sda_low = 1'b0; ext_scl_low = 1'b0;
        repeat (8) tick();
        chk("R7 stays released", sda_pull, 0);
        pulse_clr_bcol();
        chk("R8 bcol cleared after abort", bcol_flag, 0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_start(3, 1'b0, "r3load");
        t_start(0, 1'b0, "R5 zero");
        t_start(7, 1'b1, "r7busy");
        t_refuse(1'b0);
        t_refuse(1'b1);
        t_abort(1'b0);
        t_abort(1'b1);
        t_start(2, 1'b0, "after");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule